// File: doc/BRIEF.md
# Fifteen-Cent Coin Vending Controller

This block is the control state machine of a single-slot coin machine that sells one item for 15 cents. A coin sensor upstream raises a one-cycle pulse on one of two inputs: one for a 5-cent coin and one for a 10-cent coin. The controller keeps the credit collected so far in a two-bit state and raises a release output once that credit reaches 15 cents or more. No change is given, so paying 20 cents still releases exactly one item.

The release output comes from a register and depends only on the present state, never directly on the coin inputs. It stays high for a single clock cycle, and then the controller drops back to zero credit for the next sale. An idle cycle keeps the credit as it is. A cycle in which both coin pulses are high is treated as a sensor fault and also keeps the credit as it is.

Top module: `vend_ctrl`

## Requirements
- R1: While the active-low asynchronous reset `rst_n` is low, and after it is released, the credit is zero and `open_o` is 0. A reset in the middle of a sale discards the credit collected so far.
- R2: A cycle with `nickel_i`=1 and `dime_i`=0 adds 5 cents on the next clock edge. The credit moves from 0 to 5, from 5 to 10, and from 10 to the paid state.
- R3: A cycle with `dime_i`=1 and `nickel_i`=0 adds 10 cents on the next clock edge. The credit moves from 0 to 10, from 5 to paid, and from 10 to paid. Overpayment to 20 cents gives the same single release as exact payment.
- R4: `open_o` is 1 exactly in the cycle after the edge that took the credit to 15 cents or more. It is a Moore output: a change on the coin inputs during a cycle does not change `open_o` in that cycle.
- R5: A cycle with `nickel_i`=0 and `dime_i`=0 leaves the credit unchanged.
- R6: A cycle with `nickel_i`=1 and `dime_i`=1 is an illegal input and leaves the credit unchanged.
- R7: The paid state lasts one cycle. On the next edge the credit returns to zero, and any coin pulse seen during the release cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nickel_i | input | 1 | One-cycle pulse for a 5-cent coin |
| dime_i | input | 1 | One-cycle pulse for a 10-cent coin |
| open_o | output | 1 | Item release, high for one cycle per sale |

## Verification
The bench drives several coin patterns:
- 5+5+5 and 5+10 land exactly on the price.
- 10+10 overpays.
- 10+5 reaches the price by the other order.

These patterns separate the two adders and show whether the credit saturates correctly. Idle gaps between coins and cycles with both pulses high show whether the credit is held rather than cleared or advanced. Coins that arrive during the release cycle, followed by a fresh sale, show whether the controller returns cleanly to zero. A mid-sale reset and an input change within a cycle show the reset behaviour and that the output follows the state only.

// File: rtl/vend_pkg.sv
package vend_pkg;

    // credit counted in units of the smallest coin (5 cents)
    localparam int unsigned CRED_W       = 2;
    localparam int unsigned NICKEL_UNITS = 1;
    localparam int unsigned DIME_UNITS   = 2;
    localparam int unsigned PRICE_UNITS  = 3;
    localparam int unsigned SUM_W        = CRED_W + 1;

    typedef enum logic [CRED_W-1:0] {
        CR_0    = 2'b00,
        CR_5    = 2'b01,
        CR_10   = 2'b10,
        CR_PAID = 2'b11
    } cred_e;

    typedef enum logic [1:0] {
        COIN_NONE   = 2'b00,
        COIN_NICKEL = 2'b01,
        COIN_DIME   = 2'b10,
        COIN_BAD    = 2'b11
    } coin_e;

    typedef struct packed {
        cred_e cred;
        logic  open;
    } ctrl_s;

endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode
    import vend_pkg::*;
(
    input  logic  nickel_i,
    input  logic  dime_i,
    output coin_e coin_o
);

    always_comb begin
        unique case ({dime_i, nickel_i})
            2'b01:   coin_o = COIN_NICKEL;
            2'b10:   coin_o = COIN_DIME;
            2'b11:   coin_o = COIN_BAD;
            default: coin_o = COIN_NONE;
        endcase
    end

endmodule

// File: rtl/vend_next_credit.sv
module vend_next_credit
    import vend_pkg::*;
(
    input  cred_e cred_i,
    input  coin_e coin_i,
    output cred_e cred_o
);

    logic [SUM_W-1:0] add_units;
    logic [SUM_W-1:0] sum;

    always_comb begin
        unique case (coin_i)
            COIN_NICKEL: add_units = SUM_W'(NICKEL_UNITS);
            COIN_DIME:   add_units = SUM_W'(DIME_UNITS);
            default:     add_units = '0;
        endcase
        sum = {1'b0, cred_i} + add_units;

        if (cred_i == CR_PAID) begin
            cred_o = CR_0;
        end else if (sum >= SUM_W'(PRICE_UNITS)) begin
            cred_o = CR_PAID;
        end else begin
            cred_o = cred_e'(sum[CRED_W-1:0]);
        end
    end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nickel_i,
    input  logic dime_i,
    output logic open_o
);

    coin_e coin;
    cred_e cred_next;
    ctrl_s ctrl_d, ctrl_q;

    vend_coin_decode i_decode (
        .nickel_i (nickel_i),
        .dime_i   (dime_i),
        .coin_o   (coin)
    );

    vend_next_credit i_next (
        .cred_i (ctrl_q.cred),
        .coin_i (coin),
        .cred_o (cred_next)
    );

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.cred = cred_next;
        ctrl_d.open = (cred_next == CR_PAID);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.cred <= CR_0;
            ctrl_q.open <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign open_o = ctrl_q.open;

    // release lasts one cycle
    assert_one_cycle_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        open_o |=> !open_o);

    // after release, credit back at zero
    assert_clear_after_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        open_o |=> (ctrl_q.cred == CR_0));

    // idle cycle keeps credit
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!nickel_i && !dime_i && !open_o) |=> $stable(ctrl_q.cred));

    // both coins at once keep credit
    assert_both_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (nickel_i && dime_i && !open_o) |=> $stable(ctrl_q.cred));

    // a dime on 5 or 10 cents pays
    assert_dime_pays_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dime_i && !nickel_i && (ctrl_q.cred == CR_5 || ctrl_q.cred == CR_10))
        |=> open_o);

    // a nickel from zero gives 5 cents
    assert_nickel_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (nickel_i && !dime_i && ctrl_q.cred == CR_0) |=> (ctrl_q.cred == CR_5));

endmodule

// File: tb/test_vend_ctrl.sv
module test_vend_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nickel_i = 1'b0;
    logic dime_i = 1'b0;
    logic open_o;

    int n_vec = 0;
    int n_bad = 0;
    int model_cents = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vend_ctrl i_vend_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .nickel_i (nickel_i),
        .dime_i   (dime_i),
        .open_o   (open_o)
    );

    function automatic logic exp_open();
        return (model_cents >= 15);
    endfunction

    task automatic check(input string tag);
        n_vec++;
        if (open_o !== exp_open()) begin
            n_bad++;
            $display("FAIL %s: open_o=%b expected %b (model credit %0d)",
                     tag, open_o, exp_open(), model_cents);
        end
    endtask

    // drive one cycle, update model at the edge, compare at the falling edge
    task automatic step(input logic n, input logic d, input string tag);
        nickel_i = n;
        dime_i   = d;
        @(posedge clk);
        if (model_cents >= 15) model_cents = 0;
        else if (n && !d) model_cents = model_cents + 5;
        else if (d && !n) model_cents = model_cents + 10;
        @(negedge clk);
        nickel_i = 1'b0;
        dime_i   = 1'b0;
        check(tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        // R2: 5+5+5, with R7 return to zero
        step(1, 0, "R2");
        step(1, 0, "R2");
        step(1, 0, "R2");
        step(0, 0, "R7");

        // R3: 5 then 10 exact
        step(1, 0, "R3");
        step(0, 1, "R3");
        step(0, 0, "R7");

        // R3: 10+10 overpay, single release
        step(0, 1, "R3");
        step(0, 1, "R3");
        step(0, 0, "R7");
        step(0, 0, "R7");

        // R2: 10 then 5
        step(0, 1, "R2");
        step(1, 0, "R2");
        step(0, 0, "R7");

        // R5: idle gaps keep credit
        step(1, 0, "R5");
        repeat (4) step(0, 0, "R5");
        step(1, 0, "R5");
        repeat (3) step(0, 0, "R5");
        step(1, 0, "R5");
        step(0, 0, "R5");

        // R6: both coins ignored, from 0 and from 10
        step(1, 1, "R6");
        step(1, 1, "R6");
        step(0, 1, "R6");
        step(1, 1, "R6");
        step(1, 1, "R6");
        step(1, 0, "R6");
        step(0, 0, "R6");

        // R7: coins during release discarded
        step(0, 1, "R7");
        step(1, 0, "R7");
        step(0, 1, "R7");
        step(1, 0, "R7");
        step(1, 0, "R7");
        step(1, 0, "R7");
        step(0, 0, "R7");

        // R4: Moore output, input change within a cycle has no effect
        step(0, 1, "R4");
        dime_i = 1'b1;
        #2;
        check("R4");
        dime_i = 1'b0;
        step(0, 1, "R4");
        nickel_i = 1'b1;
        #2;
        check("R4");
        nickel_i = 1'b0;
        step(0, 0, "R4");

        // R1: reset mid-sale clears credit
        step(0, 1, "R1");
        rst_n = 1'b0;
        model_cents = 0;
        #2;
        check("R1");
        @(negedge clk);
        rst_n = 1'b1;
        check("R1");
        step(1, 0, "R1");
        step(1, 0, "R1");
        step(1, 0, "R1");
        step(0, 0, "R1");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule